// File: doc/BRIEF.md
# Pulse-Swallow Synthesizer Divider Chain

This block holds the two digital dividers that feed the phase comparator of a frequency synthesizer. The reference path divides the reference clock by one of three ratios, selected by a 2-bit code. At a reference of about 10.1 MHz the three ratios give comparison rates near 1.01 MHz, 505 kHz and 253 kHz. The comparison rate is also the step size of the synthesized output. The feedback path divides the oscillator clock with a counted dual-modulus prescaler and then halves the result. It stays in divide-by-33 mode while the swallow counter has budget left, then runs in divide-by-32 mode until the main counter completes. The total feedback ratio is therefore 2·(32·N + A).

The divider settings are static parallel inputs. A new setting is taken only at the boundary of a full output period, so a change never shortens an output cycle. A setting where the swallow count is larger than the main count, or where the main count is zero, is flagged at once. The flag does not disturb the divider, which keeps running at its last legal ratio.

Top module: `pll_div_chain`

## Requirements
- R1: While `rst_n` is low, `ref_pulse` and `fb_pulse` are both low.
- R2: With `ref_sel` = 00, 01 and 10, rising edges of `ref_pulse` are spaced 10, 20 and 40 `ref_clk` cycles apart.
- R3: The reserved code `ref_sel` = 11 gives a spacing of 10 `ref_clk` cycles.
- R4: Every high phase of `ref_pulse` and of `fb_pulse` lasts exactly one cycle of its own clock.
- R5: With a legal setting (1 ≤ N, A ≤ N), rising edges of `fb_pulse` are spaced 2·(32·N + A) `vco_clk` cycles apart.
- R6: The two swallow extremes hold: A = 0 gives 64·N cycles and A = N gives 66·N cycles.
- R7: `cfg_err` is high without any clock delay whenever `a_div` > `n_div` or `n_div` = 0, and is low otherwise.
- R8: While a setting is illegal, the feedback path keeps the spacing of the last legal setting.
- R9: A change of `ref_sel` made after a reference pulse has been output does not affect the period that has just started. The new ratio applies from the period that follows it.
- R10: A change of `n_div`/`a_div` made after a feedback pulse has been output does not affect the period that has just started. The new ratio applies from the period that follows it.
- R11: The largest setting, N = 511 and A = 31, gives a spacing of 32766 `vco_clk` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock |
| vco_clk | input | 1 | Oscillator clock, input of the feedback path |
| rst_n | input | 1 | Asynchronous active-low reset for both paths |
| ref_sel | input | 2 | Reference ratio code: 00 gives ÷10, 01 gives ÷20, 10 gives ÷40, 11 gives ÷10 |
| n_div | input | 9 | Main counter setting N |
| a_div | input | 5 | Swallow counter setting A |
| ref_pulse | output | 1 | One-cycle comparison pulse of the reference path |
| fb_pulse | output | 1 | One-cycle comparison pulse of the feedback path |
| cfg_err | output | 1 | High while the feedback setting is illegal |

## Verification
Some properties are checked by assertions on every cycle. Each pulse lasts a single cycle, and every reference pulse coincides with a restart of the reference count. The stored feedback ratio always stays legal. The active ratios of both paths change only at a period boundary, and never while an illegal setting is presented. Other behaviour can only be shown by the bench scenarios, which measure the spacing between pulses. These cover the exact divide ratios for each code, both swallow extremes, the largest setting, the one-period delay before a changed setting takes effect, and the old spacing holding while a setting is rejected.

// File: rtl/pll_div_chain.sv
module pll_div_chain #(
  parameter int N_W = 9,
  parameter int A_W = 5,
  parameter logic [N_W-1:0] RST_N = 1,
  parameter logic [A_W-1:0] RST_A = 0
) (
  input  logic           ref_clk,
  input  logic           vco_clk,
  input  logic           rst_n,
  input  logic [1:0]     ref_sel,
  input  logic [N_W-1:0] n_div,
  input  logic [A_W-1:0] a_div,
  output logic           ref_pulse,
  output logic           fb_pulse,
  output logic           cfg_err
);
  localparam int R_W = 6;
  localparam int P_W = 6;

  function automatic logic [R_W-1:0] ref_last(input logic [1:0] s);
    case (s)
      2'b01:   return R_W'(19);
      2'b10:   return R_W'(39);
      default: return R_W'(9);
    endcase
  endfunction

  logic [R_W-1:0] rcnt, rlim;
  logic           rprime, rwrap;

  assign rwrap = (rcnt == rlim);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt      <= '0;
      rlim      <= R_W'(9);
      rprime    <= 1'b1;
      ref_pulse <= 1'b0;
    end else begin
      rprime    <= 1'b0;
      ref_pulse <= !rprime && rwrap;
      if (rprime || rwrap) begin
        rcnt <= '0;
        rlim <= ref_last(ref_sel);
      end else begin
        rcnt <= rcnt + 1'b1;
      end
    end
  end

  logic [N_W-1:0] n_act, n_cnt;
  logic [A_W-1:0] a_act, a_cnt;
  logic [P_W-1:0] pc;
  logic           half, fprime;
  logic           swallow, pc_last, n_last, full_end, load;

  assign cfg_err  = ({{(N_W-A_W){1'b0}}, a_div} > n_div) || (n_div == '0);
  assign swallow  = (a_cnt != a_act);
  assign pc_last  = (pc == (swallow ? P_W'(32) : P_W'(31)));
  assign n_last   = (n_cnt == n_act - 1'b1);
  assign full_end = pc_last && n_last && half;
  assign load     = fprime || full_end;

  always_ff @(posedge vco_clk or negedge rst_n) begin
    if (!rst_n) begin
      pc       <= '0;
      n_cnt    <= '0;
      a_cnt    <= '0;
      half     <= 1'b0;
      fprime   <= 1'b1;
      n_act    <= RST_N;
      a_act    <= RST_A;
      fb_pulse <= 1'b0;
    end else begin
      fprime   <= 1'b0;
      fb_pulse <= !fprime && full_end;
      if (load) begin
        pc    <= '0;
        n_cnt <= '0;
        a_cnt <= '0;
        half  <= 1'b0;
        if (!cfg_err) begin
          n_act <= n_div;
          a_act <= a_div;
        end
      end else if (pc_last) begin
        pc <= '0;
        if (n_last) begin
          n_cnt <= '0;
          a_cnt <= '0;
          half  <= ~half;
        end else begin
          n_cnt <= n_cnt + 1'b1;
          if (swallow) a_cnt <= a_cnt + 1'b1;
        end
      end else begin
        pc <= pc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pll_div_chain_chk.sv
module pll_div_chain_chk #(
  parameter int N_W = 9,
  parameter int A_W = 5
) (
  input logic           ref_clk,
  input logic           vco_clk,
  input logic           rst_n,
  input logic           ref_pulse,
  input logic           fb_pulse,
  input logic           cfg_err,
  input logic [5:0]     rcnt,
  input logic [5:0]     rlim,
  input logic           rprime,
  input logic           fprime,
  input logic           full_end,
  input logic [N_W-1:0] n_act,
  input logic [A_W-1:0] a_act
);
  a_r4_ref_single: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ref_pulse |=> !ref_pulse);

  a_r4_fb_single: assert property (@(posedge vco_clk) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse);

  a_r2_pulse_restart: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ref_pulse |-> (rcnt == '0));

  a_r9_ref_hold: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!rprime && rcnt != rlim) |=> $stable(rlim));

  a_r10_fb_hold: assert property (@(posedge vco_clk) disable iff (!rst_n)
    !(fprime || full_end) |=> ($stable(n_act) && $stable(a_act)));

  a_r8_err_keeps: assert property (@(posedge vco_clk) disable iff (!rst_n)
    (full_end && cfg_err) |=> ($stable(n_act) && $stable(a_act)));

  a_r5_active_legal: assert property (@(posedge vco_clk) disable iff (!rst_n)
    ({{(N_W-A_W){1'b0}}, a_act} <= n_act) && (n_act != '0));
endmodule

bind pll_div_chain pll_div_chain_chk #(.N_W(N_W), .A_W(A_W)) u_chk (
  .ref_clk(ref_clk), .vco_clk(vco_clk), .rst_n(rst_n),
  .ref_pulse(ref_pulse), .fb_pulse(fb_pulse), .cfg_err(cfg_err),
  .rcnt(rcnt), .rlim(rlim), .rprime(rprime), .fprime(fprime),
  .full_end(full_end), .n_act(n_act), .a_act(a_act)
);

// File: tb/pll_div_chain_tb.sv
module pll_div_chain_tb;
  localparam int CLK_PERIOD = 10;
  localparam int VCO_PERIOD = 4;
  localparam int WD_CYCLES  = 190000;

  logic       ref_clk = 0, vco_clk = 0, rst_n = 0;
  logic [1:0] ref_sel = 2'b00;
  logic [8:0] n_div = 9'd3;
  logic [4:0] a_div = 5'd1;
  logic       ref_pulse, fb_pulse, cfg_err;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) ref_clk = ~ref_clk;
  always #(VCO_PERIOD/2) vco_clk = ~vco_clk;

  pll_div_chain u_dut (
    .ref_clk(ref_clk), .vco_clk(vco_clk), .rst_n(rst_n),
    .ref_sel(ref_sel), .n_div(n_div), .a_div(a_div),
    .ref_pulse(ref_pulse), .fb_pulse(fb_pulse), .cfg_err(cfg_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sync_ref();
    do @(negedge ref_clk); while (!ref_pulse);
  endtask
  task automatic next_ref(output int p);
    p = 0;
    do begin @(negedge ref_clk); p++; end while (!ref_pulse);
  endtask
  task automatic sync_fb();
    do @(negedge vco_clk); while (!fb_pulse);
  endtask
  task automatic next_fb(output int p);
    p = 0;
    do begin @(negedge vco_clk); p++; end while (!fb_pulse);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge vco_clk);
    chk("R1 ref_pulse in reset", int'(ref_pulse), 0);
    chk("R1 fb_pulse in reset", int'(fb_pulse), 0);
    #1 rst_n = 1;
  endtask

  task automatic t_ref_codes();
    int p;
    for (int c = 0; c < 4; c++) begin
      ref_sel = 2'(c);
      sync_ref();
      next_ref(p);
      if (c == 3) chk("R3 reserved code", p, 10);
      else        chk($sformatf("R2 code %0d", c), p, 10 << c);
    end
  endtask

  task automatic t_widths();
    sync_ref();
    @(negedge ref_clk);
    chk("R4 ref pulse width", int'(ref_pulse), 0);
    sync_fb();
    @(negedge vco_clk);
    chk("R4 fb pulse width", int'(fb_pulse), 0);
  endtask

  task automatic fb_case(input string tag, input int n, input int a);
    int p;
    n_div = 9'(n); a_div = 5'(a);
    sync_fb();
    next_fb(p);
    chk(tag, p, 2 * (32 * n + a));
  endtask

  task automatic t_fb_ratios();
    fb_case("R5 N=3 A=1", 3, 1);
    fb_case("R5 N=1 A=1", 1, 1);
    fb_case("R5 N=7 A=2", 7, 2);
    fb_case("R6 A=0 N=5", 5, 0);
    fb_case("R6 A=N=5", 5, 5);
  endtask

  task automatic t_err();
    int p;
    n_div = 9'd3; a_div = 5'd4; #1;
    chk("R7 A>N flag", int'(cfg_err), 1);
    n_div = 9'd0; a_div = 5'd0; #1;
    chk("R7 N=0 flag", int'(cfg_err), 1);
    n_div = 9'd4; a_div = 5'd4; #1;
    chk("R7 A=N no flag", int'(cfg_err), 0);
    fb_case("R8 legal before", 4, 3);
    n_div = 9'd2; a_div = 5'd7;
    sync_fb();
    next_fb(p);
    chk("R8 illegal keeps ratio", p, 2 * (32 * 4 + 3));
  endtask

  task automatic t_ref_change();
    int p;
    ref_sel = 2'b00;
    sync_ref();
    next_ref(p);
    ref_sel = 2'b10;
    next_ref(p);
    chk("R9 period in progress", p, 10);
    next_ref(p);
    chk("R9 next period", p, 40);
  endtask

  task automatic t_fb_change();
    int p;
    fb_case("R10 before change", 3, 1);
    n_div = 9'd4; a_div = 5'd2;
    next_fb(p);
    chk("R10 period in progress", p, 194);
    next_fb(p);
    chk("R10 next period", p, 260);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge vco_clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_ref_codes();
    t_widths();
    t_fb_ratios();
    t_err();
    t_ref_change();
    t_fb_change();
    fb_case("R11 max N=511 A=31", 511, 31);
    finish_run();
  end
endmodule